// File: doc/BRIEF.md
# L2 Coherence Message Event Classifier

This block sits in front of the line controller of a shared L2 cache bank. It takes coherence traffic from three inbound channels and turns each message into a single event code for the controller. The channels are requests from the private L1 caches, responses from the L1s or from memory, and unblock notices from requesters that have finished a transaction. Each event carries an address and a source ID. The request channel is classified against lookup results supplied alongside it: tag hit, free way in the set, whether the requester is a recorded sharer, and the victim's address and dirty bit.

When a request misses and its set has no free way, the block does not accept the request. It emits an eviction event for the victim address instead and keeps emitting one on every cycle the request is offered that way. Once the controller has freed the way, the same request is classified normally and accepted. Response and ack messages carry their own classification: data from an L1 splits on its dirty flag, and an ack is the last one when the pending count minus the ack count is zero.

A two-state machine records malformed traffic. It starts in `ST_CLEAN` and moves to `ST_FAULT` on any accepted message whose type is not defined for its channel. It stays in `ST_FAULT` until reset. Events are registered and appear one cycle after the handshake.

Top module: `l2_event_classifier`

## Requirements
- R1: Response channel has highest priority and `rsp_ready` is always 1. `ubl_ready` equals `!rsp_valid`. `req_ready` is 1 only when neither `rsp_valid` nor `ubl_valid` is set and the request does not need an eviction (see R4).
- R2: `evt_valid` is high for exactly one cycle, the cycle after a granted well-formed message (an accepted response or unblock, or a request that is accepted or evicting). It is low otherwise.
- R3: A request of kind 0 (read shared), 1 (read for instruction) or 2 (read for ownership) that hits, or misses with a free way, gives event 0, 1 or 2 respectively. The event carries `req_addr` and `req_id`.
- R4: A well-formed request that misses with no free way is not accepted. It gives event 6 (dirty eviction) when `lk_victim_dirty` is 1, else event 7 (clean eviction). The event address is `lk_victim_addr`.
- R5: A request of kind 3 (upgrade) gives event 3 only if the tag hits and the requester is a sharer. Otherwise it gives event 2.
- R6: A request of kind 4 (writeback) gives event 4 when the tag hits and the requester is a sharer. Otherwise it gives event 5 (stale writeback).
- R7: A response from an L1 (`rsp_from_l1`=1) of kind 0 (data) gives event 8 if `rsp_dirty` is 1, else event 9.
- R8: A response from memory (`rsp_from_l1`=0) of kind 2 gives event 12 (memory data) and of kind 3 gives event 13 (memory ack).
- R9: An L1 response of kind 1 (ack) gives event 11 when `pend_acks - rsp_ack_cnt` is zero modulo 2^CNT_W, else event 10.
- R10: An unblock of kind 0 gives event 14 and of kind 1 gives event 15.
- R11: An accepted message with an undefined type produces no event. Undefined types are request kinds 5-7, L1 response kinds 2-3, memory response kinds 0-1 and unblock kinds 2-3. Such a message is consumed and sets `err_sticky` from the next cycle until reset.
- R12: During and just after reset, `evt_valid` and `err_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 3 | Request kind |
| req_id | input | IDW | Requester ID |
| req_addr | input | AW | Request address |
| lk_tag_hit | input | 1 | Request address present in the bank |
| lk_free_way | input | 1 | Set has an unused way |
| lk_is_sharer | input | 1 | Requester is in the line's sharer set |
| lk_victim_dirty | input | 1 | Victim line is dirty |
| lk_victim_addr | input | AW | Victim line address |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response accepted |
| rsp_from_l1 | input | 1 | 1 = sender is an L1, 0 = memory |
| rsp_kind | input | 2 | Response kind |
| rsp_dirty | input | 1 | Data carried is dirty |
| rsp_ack_cnt | input | CNT_W | Acks covered by this message |
| rsp_id | input | IDW | Sender ID |
| rsp_addr | input | AW | Response address |
| pend_acks | input | CNT_W | Acks still outstanding for this address |
| ubl_valid | input | 1 | Unblock offered |
| ubl_ready | output | 1 | Unblock accepted |
| ubl_kind | input | 2 | Unblock kind |
| ubl_id | input | IDW | Sender ID |
| ubl_addr | input | AW | Unblock address |
| evt_valid | output | 1 | Event present |
| evt_code | output | 4 | Event code |
| evt_addr | output | AW | Address the event applies to |
| evt_id | output | IDW | Source ID of the message |
| err_sticky | output | 1 | Malformed traffic seen since reset |

## Verification
Several properties are checked on every clock:
- At most one channel completes a handshake per cycle.
- An event follows an offered message.
- Eviction events carry the previous cycle's victim address.
- Last-ack events coincide with an ack count equal to the pending count.
- The fault flag never drops.

The mapping of every type, lookup combination and priority conflict to its exact event code, address and ID is shown only by the bench's reference model. That model is driven through directed cases and long random runs, and compared every cycle. The refusal and repeated eviction of a request offered while its set is full is also shown there.

// File: rtl/l2cls_pkg.sv
package l2cls_pkg;

    typedef enum logic [2:0] {
        RK_RD_SHARED = 3'd0,
        RK_RD_INSTR  = 3'd1,
        RK_RD_OWN    = 3'd2,
        RK_UPGRADE   = 3'd3,
        RK_WRITEBACK = 3'd4
    } req_kind_e;

    typedef enum logic [1:0] {
        SK_L1_DATA  = 2'd0,
        SK_L1_ACK   = 2'd1,
        SK_MEM_DATA = 2'd2,
        SK_MEM_ACK  = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        UK_PLAIN = 2'd0,
        UK_EXCL  = 2'd1
    } ubl_kind_e;

    typedef enum logic [3:0] {
        EV_RD_SHARED   = 4'd0,
        EV_RD_INSTR    = 4'd1,
        EV_RD_OWN      = 4'd2,
        EV_UPGRADE     = 4'd3,
        EV_WB          = 4'd4,
        EV_WB_STALE    = 4'd5,
        EV_EVICT_DIRTY = 4'd6,
        EV_EVICT_CLEAN = 4'd7,
        EV_L1_DIRTY    = 4'd8,
        EV_L1_CLEAN    = 4'd9,
        EV_ACK_SOME    = 4'd10,
        EV_ACK_LAST    = 4'd11,
        EV_MEM_FILL    = 4'd12,
        EV_MEM_DONE    = 4'd13,
        EV_UNBLK       = 4'd14,
        EV_UNBLK_EXCL  = 4'd15
    } event_e;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } fault_st_e;

endpackage

// File: rtl/l2cls_req_decode.sv
module l2cls_req_decode
    import l2cls_pkg::*;
(
    input  logic      [2:0] kind,
    input  logic            tag_hit,
    input  logic            free_way,
    input  logic            is_sharer,
    input  logic            victim_dirty,
    output event_e          code,
    output logic            use_victim,
    output logic            bad
);
    logic room;
    logic owned_copy;

    assign room       = tag_hit || free_way;
    assign owned_copy = tag_hit && is_sharer;

    always_comb begin
        code       = EV_RD_SHARED;
        use_victim = 1'b0;
        bad        = 1'b0;
        if (kind > 3'(RK_WRITEBACK)) begin
            bad = 1'b1;
        end else if (!room) begin
            use_victim = 1'b1;
            code       = victim_dirty ? EV_EVICT_DIRTY : EV_EVICT_CLEAN;
        end else begin
            unique case (req_kind_e'(kind))
                RK_RD_SHARED: code = EV_RD_SHARED;
                RK_RD_INSTR:  code = EV_RD_INSTR;
                RK_RD_OWN:    code = EV_RD_OWN;
                RK_UPGRADE:   code = owned_copy ? EV_UPGRADE : EV_RD_OWN;
                RK_WRITEBACK: code = owned_copy ? EV_WB : EV_WB_STALE;
                default:      code = EV_RD_SHARED;
            endcase
        end
    end

endmodule

// File: rtl/l2cls_rsp_decode.sv
module l2cls_rsp_decode
    import l2cls_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             from_l1,
    input  logic       [1:0] rsp_kind,
    input  logic             dirty,
    input  logic [CNT_W-1:0] pend,
    input  logic [CNT_W-1:0] cnt,
    input  logic       [1:0] ubl_kind,
    output event_e           rsp_code,
    output logic             rsp_bad,
    output event_e           ubl_code,
    output logic             ubl_bad
);
    logic [CNT_W-1:0] left;
    assign left = pend - cnt;

    always_comb begin
        rsp_code = EV_L1_CLEAN;
        rsp_bad  = 1'b0;
        unique case (rsp_kind_e'(rsp_kind))
            SK_L1_DATA: begin
                rsp_bad  = !from_l1;
                rsp_code = dirty ? EV_L1_DIRTY : EV_L1_CLEAN;
            end
            SK_L1_ACK: begin
                rsp_bad  = !from_l1;
                rsp_code = (left == '0) ? EV_ACK_LAST : EV_ACK_SOME;
            end
            SK_MEM_DATA: begin
                rsp_bad  = from_l1;
                rsp_code = EV_MEM_FILL;
            end
            SK_MEM_ACK: begin
                rsp_bad  = from_l1;
                rsp_code = EV_MEM_DONE;
            end
            default: rsp_bad = 1'b1;
        endcase
    end

    always_comb begin
        ubl_code = EV_UNBLK;
        ubl_bad  = 1'b0;
        case (ubl_kind)
            2'(UK_PLAIN): ubl_code = EV_UNBLK;
            2'(UK_EXCL):  ubl_code = EV_UNBLK_EXCL;
            default:      ubl_bad  = 1'b1;
        endcase
    end

endmodule

// File: rtl/l2_event_classifier.sv
module l2_event_classifier
    import l2cls_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDW   = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic       [2:0] req_kind,
    input  logic   [IDW-1:0] req_id,
    input  logic    [AW-1:0] req_addr,
    input  logic             lk_tag_hit,
    input  logic             lk_free_way,
    input  logic             lk_is_sharer,
    input  logic             lk_victim_dirty,
    input  logic    [AW-1:0] lk_victim_addr,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic             rsp_from_l1,
    input  logic       [1:0] rsp_kind,
    input  logic             rsp_dirty,
    input  logic [CNT_W-1:0] rsp_ack_cnt,
    input  logic   [IDW-1:0] rsp_id,
    input  logic    [AW-1:0] rsp_addr,
    input  logic [CNT_W-1:0] pend_acks,
    input  logic             ubl_valid,
    output logic             ubl_ready,
    input  logic       [1:0] ubl_kind,
    input  logic   [IDW-1:0] ubl_id,
    input  logic    [AW-1:0] ubl_addr,
    output logic             evt_valid,
    output logic       [3:0] evt_code,
    output logic    [AW-1:0] evt_addr,
    output logic   [IDW-1:0] evt_id,
    output logic             err_sticky
);
    event_e rq_code, rs_code, ub_code;
    logic   rq_victim, rq_bad, rs_bad, ub_bad;

    l2cls_req_decode u_req (
        .kind         (req_kind),
        .tag_hit      (lk_tag_hit),
        .free_way     (lk_free_way),
        .is_sharer    (lk_is_sharer),
        .victim_dirty (lk_victim_dirty),
        .code         (rq_code),
        .use_victim   (rq_victim),
        .bad          (rq_bad)
    );

    l2cls_rsp_decode #(.CNT_W(CNT_W)) u_rsp (
        .from_l1  (rsp_from_l1),
        .rsp_kind (rsp_kind),
        .dirty    (rsp_dirty),
        .pend     (pend_acks),
        .cnt      (rsp_ack_cnt),
        .ubl_kind (ubl_kind),
        .rsp_code (rs_code),
        .rsp_bad  (rs_bad),
        .ubl_code (ub_code),
        .ubl_bad  (ub_bad)
    );

    // fixed priority: response, then unblock, then request
    logic sel_rsp, sel_ubl, sel_req;
    assign sel_rsp = rsp_valid;
    assign sel_ubl = ubl_valid && !rsp_valid;
    assign sel_req = req_valid && !rsp_valid && !ubl_valid;

    assign rsp_ready = 1'b1;
    assign ubl_ready = !rsp_valid;
    assign req_ready = !rsp_valid && !ubl_valid && !(rq_victim && !rq_bad);

    logic          nxt_valid, nxt_bad;
    event_e        nxt_code;
    logic [AW-1:0] nxt_addr;
    logic [IDW-1:0] nxt_id;

    always_comb begin
        nxt_code = rq_code;
        nxt_addr = rq_victim ? lk_victim_addr : req_addr;
        nxt_id   = req_id;
        nxt_bad  = sel_req && rq_bad;
        if (sel_rsp) begin
            nxt_code = rs_code;
            nxt_addr = rsp_addr;
            nxt_id   = rsp_id;
            nxt_bad  = rs_bad;
        end else if (sel_ubl) begin
            nxt_code = ub_code;
            nxt_addr = ubl_addr;
            nxt_id   = ubl_id;
            nxt_bad  = ub_bad;
        end
        nxt_valid = (sel_rsp || sel_ubl || sel_req) && !nxt_bad;
    end

    // fault state machine
    fault_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CLEAN: if (nxt_bad) st_d = ST_FAULT;
            ST_FAULT: st_d = ST_FAULT;
            default:  st_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_CLEAN;
        else        st_q <= st_d;
    end

    // output register
    event_e evt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_q     <= EV_RD_SHARED;
            evt_addr  <= '0;
            evt_id    <= '0;
        end else begin
            evt_valid <= nxt_valid;
            if (nxt_valid) begin
                evt_q    <= nxt_code;
                evt_addr <= nxt_addr;
                evt_id   <= nxt_id;
            end
        end
    end

    assign evt_code   = evt_q;
    assign err_sticky = (st_q == ST_FAULT);

    assert_single_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_valid && req_ready, ubl_valid && ubl_ready, rsp_valid && rsp_ready}));

    assert_event_follows_offer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(rsp_valid || ubl_valid || req_valid));

    assert_evict_victim_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code == EV_EVICT_DIRTY || evt_code == EV_EVICT_CLEAN))
        |-> (evt_addr == $past(lk_victim_addr)));

    assert_last_ack_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_ACK_LAST) |-> $past(pend_acks == rsp_ack_cnt));

    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

endmodule

// File: tb/tb_l2_event_classifier.sv
module tb_l2_event_classifier;
    localparam int AW = 32, IDW = 4, CNT_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic req_valid, req_ready, lk_tag_hit, lk_free_way, lk_is_sharer, lk_victim_dirty;
    logic [2:0] req_kind;
    logic [IDW-1:0] req_id, rsp_id, ubl_id, evt_id;
    logic [AW-1:0] req_addr, lk_victim_addr, rsp_addr, ubl_addr, evt_addr;
    logic rsp_valid, rsp_ready, rsp_from_l1, rsp_dirty, ubl_valid, ubl_ready;
    logic [1:0] rsp_kind, ubl_kind;
    logic [CNT_W-1:0] rsp_ack_cnt, pend_acks;
    logic evt_valid, err_sticky;
    logic [3:0] evt_code;

    l2_event_classifier #(.AW(AW), .IDW(IDW), .CNT_W(CNT_W)) dut (.*);

    int checks = 0, errors = 0;
    bit m_err = 0, done = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int c);
        if (c <= 2) return "R3";
        if (c == 3) return "R5";
        if (c <= 5) return "R6";
        if (c <= 7) return "R4";
        if (c <= 9) return "R7";
        if (c <= 11) return "R9";
        if (c <= 13) return "R8";
        return "R10";
    endfunction

    // behavioural reference of the requirements
    task automatic model(output bit v, output int code, output logic [AW-1:0] a,
                         output logic [IDW-1:0] id, output bit bad, output bit rr, output bit ur);
        bit own;
        v = 0; code = 0; a = '0; id = '0; bad = 0; rr = 0;
        ur = !rsp_valid;
        own = lk_tag_hit && lk_is_sharer;
        if (rsp_valid) begin
            a = rsp_addr; id = rsp_id;
            if (rsp_from_l1) begin
                if (rsp_kind == 0) code = rsp_dirty ? 8 : 9;
                else if (rsp_kind == 1) code = (pend_acks == rsp_ack_cnt) ? 11 : 10;
                else bad = 1;
            end else begin
                if (rsp_kind == 2) code = 12;
                else if (rsp_kind == 3) code = 13;
                else bad = 1;
            end
            v = !bad;
        end else if (ubl_valid) begin
            a = ubl_addr; id = ubl_id;
            if (ubl_kind == 0) code = 14;
            else if (ubl_kind == 1) code = 15;
            else bad = 1;
            v = !bad;
        end else begin
            rr = (req_kind > 4) || lk_tag_hit || lk_free_way;
            if (req_valid) begin
                id = req_id; a = req_addr;
                if (req_kind > 4) bad = 1;
                else if (!(lk_tag_hit || lk_free_way)) begin
                    code = lk_victim_dirty ? 6 : 7; a = lk_victim_addr;
                end else if (req_kind == 3) code = own ? 3 : 2;
                else if (req_kind == 4) code = own ? 4 : 5;
                else code = req_kind;
                v = !bad;
            end
        end
    endtask

    task automatic step();
        bit v, bad, rr, ur; int code; logic [AW-1:0] a; logic [IDW-1:0] id;
        #1;
        model(v, code, a, id, bad, rr, ur);
        chk("R1 rsp_ready", rsp_ready, 1);
        chk("R1 ubl_ready", ubl_ready, ur);
        chk("R1 req_ready", req_ready, rr);
        @(posedge clk); #1;
        if (bad) m_err = 1;
        chk("R2 evt_valid", evt_valid, v);
        if (v && evt_valid) begin
            chk({tag_of(code), " evt_code"}, evt_code, code);
            chk({tag_of(code), " evt_addr"}, evt_addr, a);
            chk({tag_of(code), " evt_id"}, evt_id, id);
        end
        chk("R11 err_sticky", err_sticky, m_err);
    endtask

    task automatic idle();
        req_valid = 0; rsp_valid = 0; ubl_valid = 0;
    endtask

    task automatic req(input int k, input bit hit, input bit fr, input bit sh, input bit vd);
        idle(); req_valid = 1; req_kind = 3'(k); lk_tag_hit = hit; lk_free_way = fr;
        lk_is_sharer = sh; lk_victim_dirty = vd;
        req_addr = 32'h1000 + 32'(k); lk_victim_addr = 32'hBEEF0000 + 32'(k); req_id = 4'(k + 1);
        step();
    endtask

    task automatic rsp(input bit l1, input int k, input bit d, input int p, input int c);
        idle(); rsp_valid = 1; rsp_from_l1 = l1; rsp_kind = 2'(k); rsp_dirty = d;
        pend_acks = 4'(p); rsp_ack_cnt = 4'(c); rsp_addr = 32'h2000 + 32'(k); rsp_id = 4'(9);
        step();
    endtask

    task automatic ubl(input int k);
        idle(); ubl_valid = 1; ubl_kind = 2'(k); ubl_addr = 32'h3000 + 32'(k); ubl_id = 4'(5);
        step();
    endtask

    task automatic rand_inputs(input bit legal);
        req_valid = 1'($urandom); rsp_valid = (($urandom % 4) == 0); ubl_valid = (($urandom % 4) == 0);
        req_kind = legal ? 3'($urandom % 5) : 3'($urandom); req_id = 4'($urandom); req_addr = $urandom;
        lk_tag_hit = 1'($urandom); lk_free_way = 1'($urandom); lk_is_sharer = 1'($urandom);
        lk_victim_dirty = 1'($urandom); lk_victim_addr = $urandom;
        rsp_from_l1 = 1'($urandom); rsp_kind = 2'($urandom);
        if (legal) rsp_kind = rsp_from_l1 ? 2'($urandom % 2) : 2'(2 + $urandom % 2);
        rsp_dirty = 1'($urandom); pend_acks = 4'($urandom % 4); rsp_ack_cnt = 4'($urandom % 4);
        rsp_id = 4'($urandom); rsp_addr = $urandom;
        ubl_kind = legal ? 2'($urandom % 2) : 2'($urandom); ubl_id = 4'($urandom); ubl_addr = $urandom;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        idle(); rand_inputs(1); idle();
        repeat (3) @(posedge clk);
        #1;
        chk("R12 evt_valid in reset", evt_valid, 0);
        chk("R12 err_sticky in reset", err_sticky, 0);
        @(negedge clk); rst_n = 1;
        idle(); step();
        chk("R12 evt_valid after reset", evt_valid, 0);
        // R3 plain reads, hit and miss-with-room
        req(0, 1, 0, 0, 0); req(1, 0, 1, 0, 0); req(2, 1, 1, 0, 0);
        // R5 upgrade variants
        req(3, 1, 0, 1, 0); req(3, 1, 0, 0, 0); req(3, 0, 1, 1, 0);
        // R6 writeback from sharer and non-sharer
        req(4, 1, 0, 1, 0); req(4, 1, 0, 0, 1);
        // R4 evictions, repeated while request held
        req(0, 0, 0, 0, 1); req(0, 0, 0, 0, 1); req(3, 0, 0, 1, 0);
        // R7 / R8 / R9 responses
        rsp(1, 0, 1, 0, 0); rsp(1, 0, 0, 0, 0); rsp(0, 2, 0, 0, 0); rsp(0, 3, 0, 0, 0);
        rsp(1, 1, 0, 3, 3); rsp(1, 1, 0, 3, 1); rsp(1, 1, 0, 0, 0);
        // R10 unblocks
        ubl(0); ubl(1);
        // R1 priority with all three offered
        idle(); req_valid = 1; rsp_valid = 1; ubl_valid = 1; rsp_from_l1 = 0; rsp_kind = 2'd2;
        ubl_kind = 2'd0; step();
        rsp_valid = 0; step();
        for (int i = 0; i < 4000; i++) begin rand_inputs(1); step(); end
        chk("R11 no fault on legal traffic", err_sticky, 0);
        // R11 malformed messages
        req(6, 0, 0, 0, 1);
        idle(); step();
        chk("R11 flag set", err_sticky, 1);
        ubl(3); rsp(0, 0, 0, 0, 0); rsp(1, 3, 0, 0, 0);
        for (int i = 0; i < 2000; i++) begin rand_inputs(0); step(); end
        idle(); step();
        chk("R11 flag held", err_sticky, 1);
        summary();
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule